// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a direct-mapped cache that sits between a word-oriented processor port and a slower main-memory port. Each cache block has one tag-table entry, and each entry holds a tag, a valid flag and a dirty flag. Every memory block has exactly one possible home in the cache, so a miss always evicts the current occupant of that slot and no replacement choice is made.

The processor starts a request with a one-cycle `cpu_req_i` pulse while `cpu_busy_o` is low. The block looks the request up in the tag table. On a hit it serves the request from the data array. On a miss it first writes the old block back to memory if that block is valid and dirty. It then fills the new block from memory, one word per req/ack handshake, and finishes the pending request from the filled block. `wt_mode_i` is sampled when a request is accepted and chooses the write policy for that request. In write-through mode every write is also sent to memory straight away. In delayed mode a write only marks the block dirty.

The address split is bit-exact. Field widths are parameters: the full-size configuration has a 9-bit word field, which gives 64K words in 128 blocks of 512. The default word field is narrowed to 4 bits so that the inferred data array stays small when the block is elaborated stand-alone.

Top module: `cache_dm_wb`

## Requirements
- R1: A byte address splits, from bit 0 upward, into a BYTE_W-bit byte offset (ignored), a WORD_W-bit word-in-block field, an IDX_W-bit block index and a TAG_W-bit tag. Accesses that differ only in the byte offset reach the same word.
- R2: A request hits when the indexed entry is valid and its stored tag equals the address tag. A hit read makes no memory traffic and returns the stored word with `cpu_done_o` high in the second cycle after the cycle in which `cpu_req_i` was sampled.
- R3: With `wt_mode_i`=1 at acceptance, a write updates the cache and issues exactly one memory write of that word to its word-aligned address. The block does not become dirty.
- R4: With `wt_mode_i`=0 at acceptance, a write hit updates only the cache, makes no memory traffic, completes with the hit latency of R2, and marks the block dirty.
- R5: A miss whose victim entry is valid and dirty first writes back every word of the old block, in ascending word order, to {old tag, index, word}. All of these writes finish before any fill read starts.
- R6: A miss whose victim is invalid or clean makes no write-back. It reads the new block from memory in ascending word order starting at word 0.
- R7: After a fill the entry is valid and holds the new tag. It is clean unless the pending request is a delayed-mode write. The pending request then completes from the filled block: a read returns the filled word, and a write merges its data.
- R8: `cpu_busy_o` rises in the cycle after a request is accepted and stays high until the cycle in which the one-cycle `cpu_done_o` pulse appears. `cpu_rdata_o` is valid with the pulse for reads. The memory port is idle while the block is not busy.
- R9: The memory port moves one word per handshake. A transfer occurs on a clock edge where `mem_req_o` and `mem_ack_i` are both high. `mem_addr_o` is a byte address whose low BYTE_W bits are 0. Request, address, direction and write data hold steady until acknowledged.
- R10: Reset clears all valid and dirty flags. The first access after reset to any address misses, and dirty data held before the reset is dropped without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wt_mode_i | input | 1 | 1 = write-through, 0 = delayed write; sampled at acceptance |
| cpu_req_i | input | 1 | One-cycle request strobe, sampled while not busy |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Processor byte address |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_done_o |
| cpu_busy_o | output | 1 | Request in progress |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes one word |
| mem_rdata_i | input | DATA_W | Memory read data, valid with mem_ack_i |

## Verification
The assertions check the protocol rules on every cycle:
- the memory request holds steady until it is acknowledged, and its address is word-aligned;
- the completion pulse lasts one cycle, and busy is low while the pulse is up;
- the memory port stays quiet while the block is idle;
- a fill read is never followed directly by a memory write.

What those rules cannot show comes from the bench's scenarios, checked against a behavioural model. This covers the exact write-back and fill sequences with their addresses and data, the choice between write-through and dirty marking, merging a write into a freshly filled block, and the loss of dirty data across a reset.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned TAG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             set_dirty_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int unsigned NumBlk = 1 << IDX_W;

  logic [NumBlk-1:0] valid_q;
  logic [NumBlk-1:0] dirty_q;
  logic [TAG_W-1:0]  tag_q [NumBlk];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_i) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= 1'b0;
      end else if (set_dirty_i) begin
        dirty_q[idx_i] <= 1'b1;
      end
    end
  end

  // tags need no reset: valid gates every use
  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 11
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned Depth = 1 << AW;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 2,
  parameter int unsigned WORD_W = 4,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned TAG_W  = 11,
  localparam int unsigned ADDR_W = TAG_W + IDX_W + WORD_W + BYTE_W,
  localparam int unsigned ARR_W  = IDX_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wt_mode_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_busy_o,
  output logic              cpu_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IDX_W-1:0]  ts_idx_o,
  output logic              ts_fill_o,
  output logic [TAG_W-1:0]  ts_tag_o,
  output logic              ts_set_dirty_o,
  input  logic              ent_valid_i,
  input  logic              ent_dirty_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  output logic [ARR_W-1:0]  arr_addr_o,
  output logic              arr_we_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic [DATA_W-1:0] arr_rdata_i
);
  localparam int unsigned WordLo = BYTE_W;
  localparam int unsigned IdxLo  = BYTE_W + WORD_W;
  localparam int unsigned TagLo  = BYTE_W + WORD_W + IDX_W;

  cache_state_e state_q, state_d;

  logic [TAG_W-1:0]  r_tag_q;
  logic [IDX_W-1:0]  r_idx_q;
  logic [WORD_W-1:0] r_word_q;
  logic              r_we_q, r_wt_q;
  logic [DATA_W-1:0] r_wdata_q;
  logic [WORD_W-1:0] cnt_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;

  logic hit, last, xfer, accept;
  logic unused_byte;

  assign unused_byte = ^cpu_addr_i[BYTE_W-1:0];

  assign hit    = ent_valid_i && (ent_tag_i == r_tag_q);
  assign last   = (cnt_q == {WORD_W{1'b1}});
  assign xfer   = mem_req_o && mem_ack_i;
  assign accept = (state_q == ST_IDLE) && cpu_req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cpu_req_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit)                            state_d = (r_we_q && r_wt_q) ? ST_WTHRU : ST_IDLE;
        else if (ent_valid_i && ent_dirty_i) state_d = ST_WBACK;
        else                                state_d = ST_FILL;
      end
      ST_WBACK:  if (xfer && last) state_d = ST_FILL;
      ST_FILL:   if (xfer && last) state_d = ST_LOOKUP;
      ST_WTHRU:  if (xfer) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_LOOKUP) cnt_q <= '0;
      else if (xfer && (state_q == ST_WBACK || state_q == ST_FILL)) cnt_q <= cnt_q + 1'b1;
      done_q <= ((state_q == ST_LOOKUP) && hit && !(r_we_q && r_wt_q)) ||
                ((state_q == ST_WTHRU) && xfer);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_tag_q   <= '0;
      r_idx_q   <= '0;
      r_word_q  <= '0;
      r_we_q    <= 1'b0;
      r_wt_q    <= 1'b0;
      r_wdata_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (accept) begin
        r_tag_q   <= cpu_addr_i[TagLo +: TAG_W];
        r_idx_q   <= cpu_addr_i[IdxLo +: IDX_W];
        r_word_q  <= cpu_addr_i[WordLo +: WORD_W];
        r_we_q    <= cpu_we_i;
        r_wt_q    <= wt_mode_i;
        r_wdata_q <= cpu_wdata_i;
      end
      if ((state_q == ST_LOOKUP) && hit && !r_we_q) rdata_q <= arr_rdata_i;
    end
  end

  // tag store and data array
  assign ts_idx_o       = r_idx_q;
  assign ts_tag_o       = r_tag_q;
  assign ts_fill_o      = (state_q == ST_FILL) && xfer && last;
  assign ts_set_dirty_o = (state_q == ST_LOOKUP) && hit && r_we_q && !r_wt_q;

  always_comb begin
    if (state_q == ST_WBACK || state_q == ST_FILL) arr_addr_o = {r_idx_q, cnt_q};
    else                                          arr_addr_o = {r_idx_q, r_word_q};
    arr_we_o    = 1'b0;
    arr_wdata_o = r_wdata_q;
    if ((state_q == ST_LOOKUP) && hit && r_we_q) begin
      arr_we_o = 1'b1;
    end else if ((state_q == ST_FILL) && xfer) begin
      arr_we_o    = 1'b1;
      arr_wdata_o = mem_rdata_i;
    end
  end

  // memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {ent_tag_i, r_idx_q, cnt_q, {BYTE_W{1'b0}}};
        mem_wdata_o = arr_rdata_i;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {r_tag_q, r_idx_q, cnt_q, {BYTE_W{1'b0}}};
      end
      ST_WTHRU: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {r_tag_q, r_idx_q, r_word_q, {BYTE_W{1'b0}}};
        mem_wdata_o = r_wdata_q;
      end
      default: ;
    endcase
  end

  assign cpu_busy_o  = (state_q != ST_IDLE);
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/cache_dm_wb.sv
module cache_dm_wb #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 2,
  parameter int unsigned WORD_W = 4,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned TAG_W  = 11,
  localparam int unsigned ADDR_W = TAG_W + IDX_W + WORD_W + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wt_mode_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_busy_o,
  output logic              cpu_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned ArrW = IDX_W + WORD_W;

  logic [IDX_W-1:0]  ts_idx;
  logic              ts_fill, ts_set_dirty;
  logic [TAG_W-1:0]  ts_tag;
  logic              ent_valid, ent_dirty;
  logic [TAG_W-1:0]  ent_tag;
  logic [ArrW-1:0]   arr_addr;
  logic              arr_we;
  logic [DATA_W-1:0] arr_wdata, arr_rdata;

  cache_ctrl #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) i_ctrl (
    .clk_i, .rst_ni, .wt_mode_i, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i,
    .cpu_rdata_o, .cpu_busy_o, .cpu_done_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .ts_idx_o(ts_idx), .ts_fill_o(ts_fill), .ts_tag_o(ts_tag), .ts_set_dirty_o(ts_set_dirty),
    .ent_valid_i(ent_valid), .ent_dirty_i(ent_dirty), .ent_tag_i(ent_tag),
    .arr_addr_o(arr_addr), .arr_we_o(arr_we), .arr_wdata_o(arr_wdata), .arr_rdata_i(arr_rdata)
  );

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni,
    .idx_i(ts_idx), .fill_i(ts_fill), .fill_tag_i(ts_tag), .set_dirty_i(ts_set_dirty),
    .valid_o(ent_valid), .dirty_o(ent_dirty), .tag_o(ent_tag)
  );

  cache_data_store #(.DATA_W(DATA_W), .AW(ArrW)) i_data (
    .clk_i, .addr_i(arr_addr), .we_i(arr_we), .wdata_i(arr_wdata), .rdata_o(arr_rdata)
  );
endmodule

// File: rtl/cache_dm_wb_chk.sv
module cache_dm_wb_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_busy_o,
  input logic              cpu_done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_addr_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[BYTE_W-1:0] == '0));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !cpu_busy_o);

  assert_accept_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_busy_o) |=> cpu_busy_o);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_busy_o |-> !mem_req_o);

  assert_fill_not_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> !(mem_req_o && mem_we_o));
endmodule

bind cache_dm_wb cache_dm_wb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_busy_o(cpu_busy_o),
  .cpu_done_o(cpu_done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/test_cache_dm_wb.sv
`timescale 1ns/1ps
module test_cache_dm_wb;
  localparam int DW = 32, BW = 2, WW = 4, IW = 7, TW = 11;
  localparam int AW = TW + IW + WW + BW;
  localparam int WPB = 1 << WW;
  localparam int NBLK = 1 << IW;
  localparam int XW = 1 + AW + DW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wt_mode = 1'b0, cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_busy, cpu_done;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;

  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  cache_dm_wb #(.DATA_W(DW), .BYTE_W(BW), .WORD_W(WW), .IDX_W(IW), .TAG_W(TW)) i_cache_dm_wb (
    .clk_i(clk), .rst_ni(rst_n), .wt_mode_i(wt_mode), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .cpu_busy_o(cpu_busy), .cpu_done_o(cpu_done), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // main memory model
  logic [DW-1:0] mm [int];
  logic [XW-1:0] act_q [$];
  int lat_cnt = 0;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    int k;
    k = int'(a >> BW);
    if (mm.exists(k)) return mm[k];
    return (DW'(k) * 32'h9E37_79B1) ^ 32'h0000_5A5A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (mem_ack) begin
      if (mem_req) begin
        if (mem_we) mm[int'(mem_addr >> BW)] = mem_wdata;
        act_q.push_back({mem_we, mem_addr, mem_we ? mem_wdata : mem_rdata});
      end
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_val(mem_addr);
        lat_cnt   <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // reference cache
  bit            rv [NBLK];
  bit            rd [NBLK];
  logic [TW-1:0] rt [NBLK];
  logic [DW-1:0] rc [int];
  logic [XW-1:0] exp_q [$];

  function automatic logic [AW-1:0] mk(input int tg, input int ix, input int wd, input int by);
    return {TW'(tg), IW'(ix), WW'(wd), BW'(by)};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NBLK; i++) begin
      rv[i] = 1'b0;
      rd[i] = 1'b0;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  // returns expected read data; fills exp_q
  task automatic predict(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic wt, output logic [DW-1:0] rdat, output bit quiet);
    int ix, wd, tg;
    logic [AW-1:0] ba;
    ix = int'(a[BW+WW +: IW]);
    wd = int'(a[BW +: WW]);
    tg = int'(a[BW+WW+IW +: TW]);
    exp_q.delete();
    quiet = 1'b1;
    if (!(rv[ix] && rt[ix] == TW'(tg))) begin
      quiet = 1'b0;
      if (rv[ix] && rd[ix])
        for (int w = 0; w < WPB; w++)
          exp_q.push_back({1'b1, mk(int'(rt[ix]), ix, w, 0), rc[ix*WPB+w]});
      for (int w = 0; w < WPB; w++) begin
        ba = mk(tg, ix, w, 0);
        rc[ix*WPB+w] = mem_val(ba);
        exp_q.push_back({1'b0, ba, rc[ix*WPB+w]});
      end
      rv[ix] = 1'b1;
      rd[ix] = 1'b0;
      rt[ix] = TW'(tg);
    end
    rdat = rc[ix*WPB+wd];
    if (we) begin
      rc[ix*WPB+wd] = d;
      if (wt) begin
        quiet = 1'b0;
        exp_q.push_back({1'b1, mk(tg, ix, wd, 0), d});
      end else begin
        rd[ix] = 1'b1;
      end
    end
  endtask

  task automatic do_op(input string req, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic wt);
    logic [DW-1:0] rexp;
    bit quiet;
    int n;
    predict(we, a, d, wt, rexp, quiet);
    act_q.delete();
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; wt_mode = wt;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    n = 1;
    while (!cpu_done && n < 2000) begin
      chk("R8", "busy during request", 64'(cpu_busy), 64'd1);
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk("R8", "done pulse", 64'(cpu_done), 64'd1);
    chk("R8", "busy low at done", 64'(cpu_busy), 64'd0);
    chk(req, "transfer count", 64'(act_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      if (act_q[i] !== exp_q[i]) begin
        chk(req, $sformatf("transfer %0d", i), 64'(act_q[i]), 64'(exp_q[i]));
        break;
      end
    if (!we) chk(req, "read data", 64'(cpu_rdata), 64'(rexp));
    if (quiet) chk(req, "hit latency", 64'(n), 64'd2);
    @(negedge clk);
    chk("R8", "done is one cycle", 64'(cpu_done), 64'd0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R10", "reset busy", 64'(cpu_busy), 64'd0);
    chk("R10", "reset mem_req", 64'(mem_req), 64'd0);
    chk("R8", "reset done", 64'(cpu_done), 64'd0);
    rst_n = 1'b1;

    // R6 cold miss, R2 hits
    do_op("R6", 1'b0, mk(3, 5, 2, 0), '0, 1'b0);
    do_op("R2", 1'b0, mk(3, 5, 2, 0), '0, 1'b0);
    do_op("R2", 1'b0, mk(3, 5, 7, 0), '0, 1'b0);
    do_op("R1", 1'b0, mk(3, 5, 7, 3), '0, 1'b0);
    // R4 delayed write hit then read back
    do_op("R4", 1'b1, mk(3, 5, 2, 0), 32'hDEAD_0001, 1'b0);
    do_op("R4", 1'b0, mk(3, 5, 2, 1), '0, 1'b0);
    // R5 dirty victim written back
    do_op("R5", 1'b0, mk(9, 5, 0, 0), '0, 1'b0);
    do_op("R6", 1'b0, mk(3, 5, 2, 0), '0, 1'b0);
    // R3 write-through hit, victim stays clean
    do_op("R3", 1'b1, mk(3, 5, 3, 0), 32'hC0FF_EE03, 1'b1);
    do_op("R3", 1'b0, mk(9, 5, 3, 0), '0, 1'b0);
    // R7 delayed write miss merges and dirties
    do_op("R7", 1'b1, mk(1, 5, 15, 0), 32'hBEEF_0F0F, 1'b0);
    do_op("R7", 1'b0, mk(1, 5, 15, 0), '0, 1'b0);
    do_op("R5", 1'b0, mk(2, 5, 15, 0), '0, 1'b0);
    // R7 write-through miss: fill then single write
    do_op("R7", 1'b1, mk(12'h7FF, 127, 0, 0), 32'h1234_5678, 1'b1);
    do_op("R1", 1'b0, mk(12'h7FF, 127, 0, 2), '0, 1'b0);
    // R1 other index untouched
    do_op("R1", 1'b0, mk(4, 6, 1, 0), '0, 1'b0);
    do_op("R1", 1'b0, mk(2, 5, 9, 0), '0, 1'b0);
    // R10 dirty data lost over reset
    do_op("R10", 1'b1, mk(2, 5, 9, 0), 32'hAAAA_5555, 1'b0);
    apply_reset();
    do_op("R10", 1'b0, mk(2, 5, 9, 0), '0, 1'b0);
    do_op("R10", 1'b0, mk(12'h7FF, 127, 0, 0), '0, 1'b0);
    // R9 alternating policies across many blocks
    for (int i = 0; i < 6; i++) begin
      do_op("R9", 1'b1, mk(i + 20, 40, i, 0), 32'h5000_0000 + i, (i % 2) == 1);
      do_op("R9", 1'b0, mk(i + 20, 40, i, 0), '0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule